// File: doc/BRIEF.md
# Self-Invalidation Hint Engine

This block sits beside a node's shared second-level cache, where two hardware threads share one cache: a leader that runs ahead and a checked thread that does the real work. It keeps a small direct-mapped table of resident lines. For each line it holds a self-invalidation hint flag, a flag recording that the line was stored to inside a critical section, and a transparency flag. Hints that arrive from the directory mark resident lines. Nothing leaves the block until the checked thread reaches a synchronization point such as a barrier or an unlock. At that point a background walk visits the hinted lines and sends one coherence command per line to the memory side, through a valid/ready port.

A line written inside a critical section is treated as migratory and is invalidated. Any other hinted line is treated as producer-consumer data: it is written back and downgraded to shared, and it stays resident. Commands go out at most once every four cycles, so the walk runs alongside the synchronization without flooding the directory. A line filled by a transparent reply hits for the leader only. The checked thread sees it as a miss until a normal fill replaces it.

Top module: `si_hint_engine`

## Requirements
- R1: The table is direct-mapped. The line slot is address bits [IDX_W-1:0] and the tag is the remaining upper bits. A hint sets the hint flag only when the slot is valid and its tag matches. A hint for a non-resident address is ignored and never produces a command.
- R2: No command is sent while no synchronization event has been seen since the hints arrived. A synchronization event with no hinted line leaves `busy` low and sends nothing.
- R3: A hinted line that received a store with `st_in_crit` high since its last fill is sent with `cmd_inval` = 1. After acceptance it is no longer resident, so lookups miss.
- R4: Any other hinted line is sent with `cmd_inval` = 0, meaning write back and downgrade to shared. It stays resident.
- R5: Two successive rising edges of `cmd_valid` are at least four cycles apart.
- R6: `cmd_valid` stays high with a stable `cmd_addr` and `cmd_inval` until `cmd_ready` is seen. `cmd_addr` is the full line address, {tag, slot}. The hint flag is cleared on acceptance, so each hinted line is sent exactly once.
- R7: `look_hit` is registered and valid the cycle after `look_en`. It is 1 when the slot is valid, the tag matches, and either `look_leader` is 1 or the line was not filled transparently.
- R8: A fill clears the slot's hint flag, critical-section flag and old transparency, and then takes the new `fill_transp` value.
- R9: The walk visits slots in ascending order with wrap-around, starting at the slot after the last accepted command. It begins at slot 0 after reset. A synchronization event during a walk is merged into it and does not restart it.
- R10: `busy` goes high the cycle after a synchronization event that finds a hinted line. It stays high until every hinted line has been accepted, and then falls with `cmd_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_en | input | 1 | Line fill strobe |
| fill_addr | input | ADDR_W | Line address being filled |
| fill_transp | input | 1 | Fill came from a transparent reply |
| st_en | input | 1 | Store strobe from the checked thread |
| st_addr | input | ADDR_W | Store line address |
| st_in_crit | input | 1 | Store happens inside a critical section |
| hint_en | input | 1 | Self-invalidation hint strobe |
| hint_addr | input | ADDR_W | Hinted line address |
| look_en | input | 1 | Lookup strobe |
| look_addr | input | ADDR_W | Lookup line address |
| look_leader | input | 1 | Lookup comes from the leader thread |
| look_hit | output | 1 | Registered lookup result |
| sync_en | input | 1 | Checked thread reached a synchronization point |
| cmd_valid | output | 1 | Command to the memory side is valid |
| cmd_ready | input | 1 | Memory side accepts the command |
| cmd_addr | output | ADDR_W | Line address of the command |
| cmd_inval | output | 1 | 1 = invalidate, 0 = write back and downgrade |
| busy | output | 1 | Walk in progress |

## Verification
The bench targets a critical-section store followed by a refill of the same line. A design that failed to clear the flag on refill would invalidate a line that only needs a downgrade. It also injects a second synchronization event in the middle of a walk. A restarting walker would jump back to slot 0 and break the expected visit order. Commands are accepted with `cmd_ready` held high so that pacing is stressed at full rate, where a short spacing counter would emit commands closer than four cycles. It also checks that a transparent fill misses for the checked thread and stops doing so after a normal refill, and that a hint to a non-resident address never becomes a command.

// File: rtl/si_hint_pkg.sv
package si_hint_pkg;
  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_SCAN  = 2'd1,
    WK_ISSUE = 2'd2
  } walk_state_e;
endpackage

// File: rtl/si_line_table.sv
module si_line_table #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fill_en,
  input  logic [ADDR_W-1:0]         fill_addr,
  input  logic                      fill_transp,
  input  logic                      st_en,
  input  logic [ADDR_W-1:0]         st_addr,
  input  logic                      st_in_crit,
  input  logic                      hint_en,
  input  logic [ADDR_W-1:0]         hint_addr,
  input  logic [ADDR_W-1:0]         look_addr,
  input  logic                      look_leader,
  output logic                      look_hit_c,
  input  logic                      clr_en,
  input  logic [IDX_W-1:0]          clr_idx,
  input  logic                      clr_inval,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [ADDR_W-IDX_W-1:0]   rd_tag,
  output logic [(1<<IDX_W)-1:0]     hint_vec,
  output logic [(1<<IDX_W)-1:0]     crit_vec
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_q, hint_q, crit_q, transp_q;

  logic [IDX_W-1:0] fill_idx, st_idx, hint_idx, look_idx;
  logic [TAG_W-1:0] fill_tag, st_tag, hint_tag, look_tag;
  logic             st_hit, hint_hit;

  assign fill_idx = fill_addr[IDX_W-1:0];
  assign fill_tag = fill_addr[ADDR_W-1:IDX_W];
  assign st_idx   = st_addr[IDX_W-1:0];
  assign st_tag   = st_addr[ADDR_W-1:IDX_W];
  assign hint_idx = hint_addr[IDX_W-1:0];
  assign hint_tag = hint_addr[ADDR_W-1:IDX_W];
  assign look_idx = look_addr[IDX_W-1:0];
  assign look_tag = look_addr[ADDR_W-1:IDX_W];

  // Tag array: written only on fill, no reset, so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[fill_idx] <= fill_tag;
  end

  assign st_hit   = st_en   && valid_q[st_idx]   && (tag_mem[st_idx]   == st_tag);
  assign hint_hit = hint_en && valid_q[hint_idx] && (tag_mem[hint_idx] == hint_tag);

  assign look_hit_c = valid_q[look_idx] && (tag_mem[look_idx] == look_tag) &&
                      (look_leader || !transp_q[look_idx]);

  assign rd_tag   = tag_mem[rd_idx];
  assign hint_vec = hint_q;
  assign crit_vec = crit_q;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[i]  <= 1'b0;
        hint_q[i]   <= 1'b0;
        crit_q[i]   <= 1'b0;
        transp_q[i] <= 1'b0;
      end else if (fill_en && fill_idx == IDX_W'(i)) begin
        valid_q[i]  <= 1'b1;
        hint_q[i]   <= 1'b0;
        crit_q[i]   <= 1'b0;
        transp_q[i] <= fill_transp;
      end else begin
        if (clr_en && clr_idx == IDX_W'(i)) begin
          hint_q[i] <= 1'b0;
          if (clr_inval) valid_q[i] <= 1'b0;
        end
        if (st_hit && st_in_crit && st_idx == IDX_W'(i)) crit_q[i] <= 1'b1;
        if (hint_hit && hint_idx == IDX_W'(i)) hint_q[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/si_walker.sv
module si_walker
  import si_hint_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 12,
  parameter int MIN_GAP = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sync_en,
  input  logic [(1<<IDX_W)-1:0]  hint_vec,
  input  logic [(1<<IDX_W)-1:0]  crit_vec,
  output logic [IDX_W-1:0]       rd_idx,
  input  logic [TAG_W-1:0]       rd_tag,
  output logic                   cmd_valid,
  input  logic                   cmd_ready,
  output logic [TAG_W+IDX_W-1:0] cmd_addr,
  output logic                   cmd_inval,
  output logic                   clr_en,
  output logic [IDX_W-1:0]       clr_idx,
  output logic                   clr_inval,
  output logic                   busy
);
  localparam int GW = $clog2(MIN_GAP) + 1;

  walk_state_e      state_q;
  logic [IDX_W-1:0] ptr_q;
  logic [GW-1:0]    gap_q;
  logic             gap_load;

  assign rd_idx    = ptr_q;
  assign clr_en    = (state_q == WK_ISSUE) && cmd_valid && cmd_ready;
  assign clr_idx   = cmd_addr[IDX_W-1:0];
  assign clr_inval = cmd_inval;
  assign gap_load  = (state_q == WK_SCAN) && (hint_vec != '0) &&
                     hint_vec[ptr_q] && (gap_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0;
    end else if (gap_load) begin
      gap_q <= GW'(MIN_GAP - 1);
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= WK_IDLE;
      ptr_q     <= '0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_inval <= 1'b0;
      busy      <= 1'b0;
    end else begin
      case (state_q)
        WK_IDLE: begin
          if (sync_en && hint_vec != '0) begin
            state_q <= WK_SCAN;
            busy    <= 1'b1;
          end
        end
        WK_SCAN: begin
          // Further sync events are absorbed here: the walk simply continues.
          if (hint_vec == '0) begin
            state_q <= WK_IDLE;
            busy    <= 1'b0;
          end else if (gap_load) begin
            cmd_valid <= 1'b1;
            cmd_addr  <= {rd_tag, ptr_q};
            cmd_inval <= crit_vec[ptr_q];
            state_q   <= WK_ISSUE;
          end else if (!hint_vec[ptr_q]) begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
        WK_ISSUE: begin
          if (cmd_ready) begin
            cmd_valid <= 1'b0;
            ptr_q     <= ptr_q + 1'b1;
            state_q   <= WK_SCAN;
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/si_probe.sv
module si_probe (
  input  logic clk,
  input  logic rst,
  input  logic look_en,
  input  logic look_hit_c,
  output logic look_hit
);
  always_ff @(posedge clk) begin
    if (rst) look_hit <= 1'b0;
    else     look_hit <= look_en && look_hit_c;
  end
endmodule

// File: rtl/si_hint_engine.sv
module si_hint_engine #(
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 4,
  parameter int MIN_GAP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_transp,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              st_in_crit,
  input  logic              hint_en,
  input  logic [ADDR_W-1:0] hint_addr,
  input  logic              look_en,
  input  logic [ADDR_W-1:0] look_addr,
  input  logic              look_leader,
  output logic              look_hit,
  input  logic              sync_en,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_inval,
  output logic              busy
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic             look_hit_c, clr_en, clr_inval;
  logic [IDX_W-1:0] clr_idx, rd_idx;
  logic [TAG_W-1:0] rd_tag;
  logic [LINES-1:0] hint_vec, crit_vec;

  si_line_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
    .clk, .rst, .fill_en, .fill_addr, .fill_transp,
    .st_en, .st_addr, .st_in_crit, .hint_en, .hint_addr,
    .look_addr, .look_leader, .look_hit_c,
    .clr_en, .clr_idx, .clr_inval, .rd_idx, .rd_tag,
    .hint_vec, .crit_vec
  );

  si_walker #(.IDX_W(IDX_W), .TAG_W(TAG_W), .MIN_GAP(MIN_GAP)) u_walk (
    .clk, .rst, .sync_en, .hint_vec, .crit_vec, .rd_idx, .rd_tag,
    .cmd_valid, .cmd_ready, .cmd_addr, .cmd_inval,
    .clr_en, .clr_idx, .clr_inval, .busy
  );

  si_probe u_probe (
    .clk, .rst, .look_en, .look_hit_c, .look_hit
  );
endmodule

// File: rtl/si_hint_engine_chk.sv
module si_hint_engine_chk #(
  parameter int ADDR_W  = 16,
  parameter int MIN_GAP = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sync_en,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_inval,
  input logic              busy
);
  localparam int CW = $clog2(MIN_GAP + 1) + 1;

  logic          prev_valid, prev_busy, prev_sync;
  logic [CW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid <= 1'b0;
      prev_busy  <= 1'b0;
      prev_sync  <= 1'b0;
      since_q    <= CW'(MIN_GAP);
    end else begin
      prev_valid <= cmd_valid;
      prev_busy  <= busy;
      prev_sync  <= sync_en;
      if (cmd_valid && !prev_valid) since_q <= CW'(1);
      else if (since_q < CW'(MIN_GAP)) since_q <= since_q + 1'b1;
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_inval)));

  assert_pace_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !prev_valid) |-> (since_q >= CW'(MIN_GAP)));

  assert_cmd_in_walk_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> busy);

  assert_start_on_sync_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !prev_busy) |-> prev_sync);

  assert_end_clean_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && prev_busy) |-> (!prev_valid && !cmd_valid));
endmodule

bind si_hint_engine si_hint_engine_chk #(.ADDR_W(ADDR_W), .MIN_GAP(MIN_GAP)) u_chk (
  .clk(clk), .rst(rst), .sync_en(sync_en), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_inval(cmd_inval), .busy(busy)
);

// File: tb/test_si_hint_engine.sv
module test_si_hint_engine;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 4;
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int GAP    = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic fill_en = 0, fill_transp = 0, st_en = 0, st_in_crit = 0, hint_en = 0;
  logic look_en = 0, look_leader = 0, sync_en = 0, cmd_ready = 0;
  logic [ADDR_W-1:0] fill_addr = '0, st_addr = '0, hint_addr = '0, look_addr = '0;
  logic look_hit, cmd_valid, cmd_inval, busy;
  logic [ADDR_W-1:0] cmd_addr;

  si_hint_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .MIN_GAP(GAP)) i_si_hint_engine (
    .clk, .rst, .fill_en, .fill_addr, .fill_transp, .st_en, .st_addr, .st_in_crit,
    .hint_en, .hint_addr, .look_en, .look_addr, .look_leader, .look_hit,
    .sync_en, .cmd_valid, .cmd_ready, .cmd_addr, .cmd_inval, .busy
  );

  always #(PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit             m_valid [LINES], m_hint [LINES], m_crit [LINES], m_tr [LINES];
  logic [TAG_W-1:0] m_tag [LINES];
  int  exp_ptr = 0;
  bit  ready_all = 0;
  int  n_accept = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_hinted();
    for (int k = 0; k < LINES; k++) begin
      int j;
      j = (exp_ptr + k) % LINES;
      if (m_hint[j]) return j;
    end
    return -1;
  endfunction

  function automatic bit any_hint();
    for (int k = 0; k < LINES; k++) if (m_hint[k]) return 1;
    return 0;
  endfunction

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx);
    return {TAG_W'(tag), IDX_W'(idx)};
  endfunction

  function automatic bit resident(input logic [ADDR_W-1:0] a);
    int i;
    i = int'(a[IDX_W-1:0]);
    return m_valid[i] && m_tag[i] == a[ADDR_W-1:IDX_W];
  endfunction

  // Memory-side monitor and model update on acceptance.
  bit mon_pv = 0, mon_pr = 0;
  logic [ADDR_W-1:0] mon_pa = '0;
  logic mon_pi = 0;
  longint last_rise = -100;
  always @(negedge clk) begin
    if (!rst) begin
      bit r;
      if (cmd_valid && !mon_pv) begin
        chk(cyc - last_rise >= GAP, "R5 command spacing", cyc - last_rise, GAP);
        last_rise = cyc;
      end
      if (mon_pv && !mon_pr)
        chk(cmd_valid && cmd_addr == mon_pa && cmd_inval == mon_pi,
            "R6 hold until ready", longint'(cmd_addr), longint'(mon_pa));
      r = ready_all ? 1'b1 : ($urandom % 3 != 0);
      cmd_ready = r;
      if (cmd_valid && r) begin
        int idx, e;
        idx = int'(cmd_addr[IDX_W-1:0]);
        e = next_hinted();
        chk(idx == e, "R9 walk order", idx, e);
        chk(m_hint[idx] && m_valid[idx] && m_tag[idx] == cmd_addr[ADDR_W-1:IDX_W],
            "R6 hinted resident line", longint'(cmd_addr), longint'(mk(int'(m_tag[idx]), idx)));
        if (m_crit[idx]) chk(cmd_inval == 1'b1, "R3 invalidate migratory", cmd_inval, 1);
        else             chk(cmd_inval == 1'b0, "R4 downgrade producer-consumer", cmd_inval, 0);
        m_hint[idx] = 0;
        if (cmd_inval) m_valid[idx] = 0;
        exp_ptr = (idx + 1) % LINES;
        n_accept++;
      end
      mon_pv = cmd_valid; mon_pr = r; mon_pa = cmd_addr; mon_pi = cmd_inval;
    end
  end

  task automatic do_fill(input logic [ADDR_W-1:0] a, input bit tr);
    int i;
    fill_en = 1; fill_addr = a; fill_transp = tr;
    @(negedge clk); fill_en = 0;
    i = int'(a[IDX_W-1:0]);
    m_valid[i] = 1; m_tag[i] = a[ADDR_W-1:IDX_W]; m_hint[i] = 0; m_crit[i] = 0; m_tr[i] = tr;
  endtask

  task automatic do_store(input logic [ADDR_W-1:0] a, input bit crit);
    st_en = 1; st_addr = a; st_in_crit = crit;
    @(negedge clk); st_en = 0;
    if (resident(a) && crit) m_crit[int'(a[IDX_W-1:0])] = 1;
  endtask

  task automatic do_hint(input logic [ADDR_W-1:0] a);
    hint_en = 1; hint_addr = a;
    @(negedge clk); hint_en = 0;
    if (resident(a)) m_hint[int'(a[IDX_W-1:0])] = 1;
  endtask

  task automatic do_look(input logic [ADDR_W-1:0] a, input bit leader, input string req);
    bit e;
    int i;
    i = int'(a[IDX_W-1:0]);
    e = resident(a) && (leader || !m_tr[i]);
    look_en = 1; look_addr = a; look_leader = leader;
    @(negedge clk); look_en = 0;
    chk(look_hit == e, req, look_hit, e);
  endtask

  task automatic run_walk(input bit mid_sync);
    bit exp_busy;
    int guard;
    exp_busy = any_hint();
    chk(busy == 0 && cmd_valid == 0, "R2 quiet before sync", busy, 0);
    sync_en = 1;
    @(negedge clk); sync_en = 0;
    chk(busy == exp_busy, "R10 busy after sync", busy, exp_busy);
    if (mid_sync && busy) begin
      repeat (3) @(negedge clk);
      sync_en = 1;
      @(negedge clk); sync_en = 0;
    end
    guard = 0;
    while (busy && guard < 3000) begin
      @(negedge clk); guard++;
    end
    chk(!busy && !cmd_valid, "R10 walk ends", busy, 0);
    chk(!any_hint(), "R10 all hinted lines processed", any_hint(), 0);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && cmd_valid == 0 && look_hit == 0, "R10 reset state", busy, 0);

    // R7 / R8: transparent fill visible only to leader, cleared by a normal refill
    do_fill(mk(5, 2), 1);
    do_look(mk(5, 2), 1, "R7 leader hits transparent");
    do_look(mk(5, 2), 0, "R7 checked misses transparent");
    chk(look_hit == 0, "R7 checked thread result", look_hit, 0);
    do_fill(mk(5, 2), 0);
    do_look(mk(5, 2), 0, "R8 refill clears transparency");

    // R1: hint for a non-resident address is ignored
    do_hint(mk(9, 7));
    do_hint(mk(6, 2));
    run_walk(0);
    chk(n_accept == 0, "R1 absent-line hint sends nothing", n_accept, 0);

    // R8 + R4: critical store, then refill, then hint -> downgrade
    do_fill(mk(3, 4), 0);
    do_store(mk(3, 4), 1);
    do_fill(mk(3, 4), 0);
    do_hint(mk(3, 4));
    // R3: critical store kept -> invalidate, then miss
    do_fill(mk(1, 9), 0);
    do_store(mk(1, 9), 1);
    do_hint(mk(1, 9));
    repeat (6) @(negedge clk);
    chk(busy == 0 && cmd_valid == 0, "R2 hints wait for sync", cmd_valid, 0);
    run_walk(0);
    do_look(mk(1, 9), 1, "R3 invalidated line misses");
    do_look(mk(3, 4), 0, "R4 downgraded line stays resident");

    // R5 / R9: dense hints, ready always high, merged mid-walk sync
    ready_all = 1;
    for (int i = 0; i < 6; i++) begin
      do_fill(mk(2, 10 + i), 0);
      if (i % 2 == 0) do_store(mk(2, 10 + i), 1);
      do_hint(mk(2, 10 + i));
    end
    do_fill(mk(2, 1), 0);
    do_hint(mk(2, 1));
    run_walk(1);
    ready_all = 0;

    // Random rounds
    for (int rnd = 0; rnd < 30; rnd++) begin
      for (int op = 0; op < 10; op++) begin
        int k;
        logic [ADDR_W-1:0] a;
        k = $urandom % 5;
        a = mk($urandom % 3, $urandom % LINES);
        case (k)
          0: do_fill(a, ($urandom % 4) == 0);
          1: do_store(a, $urandom % 2);
          2, 3: do_hint(a);
          default: do_look(a, $urandom % 2, "R7 random lookup");
        endcase
      end
      run_walk(rnd % 3 == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule